// File: doc/BRIEF.md
# Iterative Serpent Block Cipher Core

This core encrypts or decrypts a single 128-bit block per operation with the Serpent cipher. The block is held as four 32-bit words, and bit position k of each word together forms one 4-bit nibble. Each round mixes in a round key, substitutes all 32 nibbles in parallel through one of eight 4-bit S-boxes, and then applies a rotate/shift/XOR transform across the words. Decryption walks the same structure backwards. It uses the inverse transform, the inverse S-boxes and the round keys in descending order.

The 33 round keys are already expanded and live outside the core. The core drives a key index, and the surrounding logic returns that 128-bit key in the same cycle. A one-cycle start request launches an operation and selects the direction. The operation takes 33 datapath cycles, each of which fetches exactly one key. A one-cycle done pulse then marks a valid result, and the result stays on the output until the next operation is accepted.

Top module: `serpent_core`

## Requirements
- R1: Encryption with `decrypt_i`=0 proceeds in rounds r = 0..31. Each round XORs key r, applies forward S-box number r mod 8 and then the linear transform, except that round 31 skips the transform and XORs key 32 instead. Word j of the block is `block_i[32*j+31:32*j]`. Word j of a key is `key_data_i[32*j+31:32*j]`. S-box input bit j at slice k is bit k of word j.
- R2: Decryption with `decrypt_i`=1 first XORs key 32. It then runs steps i = 31 down to 0. Each step applies inverse S-box i mod 8 and XORs key i. The inverse linear transform follows every step except the last one (i = 0).
- R3: Decrypting the ciphertext produced with the same round keys returns the original plaintext.
- R4: While an operation runs, `key_addr_o` steps one per cycle. It runs 0,1,...,32 when encrypting and 32,31,...,0 when decrypting.
- R5: `done_o` rises at the 33rd rising clock edge after the edge that accepts `start_i`.
- R6: `done_o` is high for exactly one cycle per operation.
- R7: A `start_i` pulse while an operation is running has no effect on that operation's result or timing.
- R8: After `done_o`, `result_o` keeps its value until a new start is accepted.
- R9: After reset, `done_o` is 0 and `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, accepted only when idle |
| decrypt_i | input | 1 | Direction: 0 encrypt, 1 decrypt, sampled with start |
| block_i | input | 128 | Input block, sampled with start |
| key_addr_o | output | 6 | Index of the round key needed this cycle |
| key_data_i | input | 128 | Round key at `key_addr_o`, valid in the same cycle |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | 128 | Result block |

## Verification
The assertions assume a zero-latency key port. They take it that `key_data_i` reflects `key_addr_o` in the same cycle and that the key table is not modified while an operation runs. The bench meets both assumptions. It serves the keys through a continuous assignment from a local array, and it rewrites that array only between operations. Start pulses that arrive during a run come from a dedicated directed case. All other requests are issued only after the previous done pulse.

// File: rtl/serpent_pkg.sv
package serpent_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 4;
  localparam int BLOCK_W    = WORD_W * NUM_WORDS;
  localparam int NUM_ROUNDS = 32;
  localparam int NUM_KEYS   = NUM_ROUNDS + 1;
  localparam int KEY_AW     = $clog2(NUM_KEYS);
  localparam int BOX_COUNT  = 8;
  localparam int BOX_AW     = $clog2(BOX_COUNT);

  typedef logic [WORD_W-1:0]              word_t;
  typedef word_t [NUM_WORDS-1:0]          block_t;
  typedef logic [BOX_AW-1:0]              box_idx_t;
  typedef logic [KEY_AW-1:0]              key_idx_t;

  // entry e of box b sits at SBOX_TBL[b][4*e +: 4]
  localparam logic [BOX_COUNT-1:0][63:0] SBOX_TBL = {
    64'h6539AC47B28E0FD1,
    64'h0A3DF19EB6485C27,
    64'h176D8E30C9A4B25F,
    64'hD7E9A4526B0C38F1,
    64'hE57A421D369C8BF0,
    64'h25B04E1DFAC39768,
    64'h43D68EB1A50972CF,
    64'hC90724DEB56A1F83
  };

  function automatic logic [3:0] sbox_fwd(box_idx_t idx, logic [3:0] v);
    return SBOX_TBL[idx][4*v +: 4];
  endfunction

  function automatic logic [3:0] sbox_inv(box_idx_t idx, logic [3:0] v);
    logic [3:0] res;
    res = '0;
    for (int e = 0; e < 16; e++) begin
      if (SBOX_TBL[idx][4*e +: 4] == v) res = 4'(e);
    end
    return res;
  endfunction

  function automatic word_t rotl(word_t w, int n);
    return (w << n) | (w >> (WORD_W - n));
  endfunction

  function automatic word_t rotr(word_t w, int n);
    return (w >> n) | (w << (WORD_W - n));
  endfunction
endpackage

// File: rtl/serpent_sbox_layer.sv
module serpent_sbox_layer
  import serpent_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  box_idx_t box_i,
  input  block_t   data_i,
  output block_t   data_o
);
  logic [3:0] sub [WORD_W];

  for (genvar k = 0; k < WORD_W; k++) begin : g_slice
    logic [3:0] nib;
    assign nib = {data_i[3][k], data_i[2][k], data_i[1][k], data_i[0][k]};
    if (INVERSE) begin : g_inv
      assign sub[k] = sbox_inv(box_i, nib);
    end else begin : g_fwd
      assign sub[k] = sbox_fwd(box_i, nib);
    end
  end

  always_comb begin
    for (int k = 0; k < WORD_W; k++) begin
      for (int j = 0; j < NUM_WORDS; j++) begin
        data_o[j][k] = sub[k][j];
      end
    end
  end
endmodule

// File: rtl/serpent_lin_mix.sv
module serpent_lin_mix
  import serpent_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  block_t data_i,
  output block_t data_o
);
  if (!INVERSE) begin : g_fwd
    word_t a0, a1, a2, a3, b0, b1, b2, b3;
    always_comb begin
      a0 = rotl(data_i[0], 13);
      a2 = rotl(data_i[2], 3);
      a1 = data_i[1] ^ a0 ^ a2;
      a3 = data_i[3] ^ a2 ^ (a0 << 3);
      b1 = rotl(a1, 1);
      b3 = rotl(a3, 7);
      b0 = a0 ^ b1 ^ b3;
      b2 = a2 ^ b3 ^ (b1 << 7);
      data_o[0] = rotl(b0, 5);
      data_o[1] = b1;
      data_o[2] = rotl(b2, 22);
      data_o[3] = b3;
    end
  end else begin : g_inv
    word_t a0, a1, a2, a3, b0, b2;
    always_comb begin
      b0 = rotr(data_i[0], 5);
      b2 = rotr(data_i[2], 22);
      a2 = b2 ^ data_i[3] ^ (data_i[1] << 7);
      a0 = b0 ^ data_i[1] ^ data_i[3];
      a1 = rotr(data_i[1], 1);
      a3 = rotr(data_i[3], 7);
      data_o[3] = a3 ^ a2 ^ (a0 << 3);
      data_o[1] = a1 ^ a0 ^ a2;
      data_o[0] = rotr(a0, 13);
      data_o[2] = rotr(a2, 3);
    end
  end
endmodule

// File: rtl/serpent_core.sv
module serpent_core
  import serpent_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               decrypt_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic [KEY_AW-1:0]  key_addr_o,
  input  logic [BLOCK_W-1:0] key_data_i,
  output logic               done_o,
  output logic [BLOCK_W-1:0] result_o
);
  localparam key_idx_t LAST_STEP = key_idx_t'(NUM_ROUNDS);
  localparam key_idx_t PRE_LAST  = key_idx_t'(NUM_ROUNDS - 1);

  block_t   state_q, state_d;
  key_idx_t step_q;
  logic     busy_q, dec_q, done_q;
  logic     accept;

  block_t   rkey, mixed, s_fwd, l_fwd, s_inv, k_inv, l_inv;
  key_idx_t dec_idx;
  box_idx_t box;

  assign accept  = start_i && !busy_q;
  assign dec_idx = LAST_STEP - step_q;
  assign key_addr_o = dec_q ? dec_idx : step_q;
  assign box     = dec_q ? dec_idx[BOX_AW-1:0] : step_q[BOX_AW-1:0];
  assign rkey    = block_t'(key_data_i);

  // encrypt path: key mix -> S -> L
  assign mixed = state_q ^ rkey;
  serpent_sbox_layer #(.INVERSE(1'b0)) i_sbox_fwd (.box_i(box), .data_i(mixed), .data_o(s_fwd));
  serpent_lin_mix    #(.INVERSE(1'b0)) i_lin_fwd  (.data_i(s_fwd), .data_o(l_fwd));

  // decrypt path: S^-1 -> key mix -> L^-1
  serpent_sbox_layer #(.INVERSE(1'b1)) i_sbox_inv (.box_i(box), .data_i(state_q), .data_o(s_inv));
  assign k_inv = s_inv ^ rkey;
  serpent_lin_mix    #(.INVERSE(1'b1)) i_lin_inv  (.data_i(k_inv), .data_o(l_inv));

  always_comb begin
    if (!dec_q) begin
      if (step_q == LAST_STEP)     state_d = mixed;
      else if (step_q == PRE_LAST) state_d = s_fwd;
      else                         state_d = l_fwd;
    end else begin
      if (step_q == '0)            state_d = mixed;
      else if (step_q == LAST_STEP) state_d = k_inv;
      else                         state_d = l_inv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      step_q  <= '0;
      busy_q  <= 1'b0;
      dec_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= block_t'(block_i);
        step_q  <= '0;
        dec_q   <= decrypt_i;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= state_d;
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = state_q;

  assert_enc_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !dec_q && key_addr_o != LAST_STEP) |=> key_addr_o == $past(key_addr_o) + 1'b1);
  assert_dec_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dec_q && key_addr_o != '0) |=> key_addr_o == $past(key_addr_o) - 1'b1);
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_q));
  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q != LAST_STEP) |=> $stable(dec_q) && busy_q);
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(result_o));
endmodule

// File: tb/test_serpent_core.sv
module test_serpent_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] blk = '0;
  logic [5:0]   key_addr;
  logic [127:0] key_data;
  logic         done;
  logic [127:0] result;

  logic [127:0] rk [33];
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign key_data = (key_addr <= 6'd32) ? rk[key_addr] : '0;

  serpent_core i_serpent_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .decrypt_i(decrypt),
    .block_i(blk), .key_addr_o(key_addr), .key_data_i(key_data),
    .done_o(done), .result_o(result)
  );

  function automatic logic [63:0] box_tbl(int b);
    case (b)
      0: return 64'hC90724DEB56A1F83;
      1: return 64'h43D68EB1A50972CF;
      2: return 64'h25B04E1DFAC39768;
      3: return 64'hE57A421D369C8BF0;
      4: return 64'hD7E9A4526B0C38F1;
      5: return 64'h176D8E30C9A4B25F;
      6: return 64'h0A3DF19EB6485C27;
      default: return 64'h6539AC47B28E0FD1;
    endcase
  endfunction

  function automatic logic [127:0] subst(logic [127:0] x, int b, bit inv);
    logic [127:0] y;
    logic [63:0]  t;
    logic [3:0]   n, m;
    t = box_tbl(b);
    y = '0;
    for (int k = 0; k < 32; k++) begin
      n = {x[96+k], x[64+k], x[32+k], x[k]};
      m = t[4*n +: 4];
      if (inv) for (int e = 0; e < 16; e++) if (t[4*e +: 4] == n) m = 4'(e);
      y[k] = m[0]; y[32+k] = m[1]; y[64+k] = m[2]; y[96+k] = m[3];
    end
    return y;
  endfunction

  function automatic logic [31:0] rl(logic [31:0] w, int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic logic [127:0] ltf(logic [127:0] x);
    logic [31:0] w0, w1, w2, w3;
    {w3, w2, w1, w0} = x;
    w0 = rl(w0, 13); w2 = rl(w2, 3);
    w1 = w1 ^ w0 ^ w2; w3 = w3 ^ w2 ^ (w0 << 3);
    w1 = rl(w1, 1); w3 = rl(w3, 7);
    w0 = w0 ^ w1 ^ w3; w2 = w2 ^ w3 ^ (w1 << 7);
    w0 = rl(w0, 5); w2 = rl(w2, 22);
    return {w3, w2, w1, w0};
  endfunction

  function automatic logic [127:0] lti(logic [127:0] x);
    logic [31:0] w0, w1, w2, w3;
    {w3, w2, w1, w0} = x;
    w0 = rl(w0, 27); w2 = rl(w2, 10);
    w0 = w0 ^ w1 ^ w3; w2 = w2 ^ w3 ^ (w1 << 7);
    w1 = rl(w1, 31); w3 = rl(w3, 25);
    w1 = w1 ^ w0 ^ w2; w3 = w3 ^ w2 ^ (w0 << 3);
    w0 = rl(w0, 19); w2 = rl(w2, 29);
    return {w3, w2, w1, w0};
  endfunction

  function automatic logic [127:0] ref_enc(logic [127:0] p);
    logic [127:0] x = p;
    for (int r = 0; r < 32; r++) begin
      x = subst(x ^ rk[r], r % 8, 1'b0);
      if (r < 31) x = ltf(x); else x = x ^ rk[32];
    end
    return x;
  endfunction

  function automatic logic [127:0] ref_dec(logic [127:0] c);
    logic [127:0] x = c ^ rk[32];
    for (int i = 31; i >= 0; i--) begin
      x = subst(x, i % 8, 1'b1) ^ rk[i];
      if (i > 0) x = lti(x);
    end
    return x;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic fill_keys(int mode);
    for (int i = 0; i < 33; i++)
      rk[i] = (mode == 0) ? '0 : (mode == 1) ? '1 : rnd128();
  endtask

  // returns result, cycles to done, key-index sequence match; optional mid-run start
  task automatic run_op(input logic [127:0] din, input bit dec, input bit poke,
                        output logic [127:0] res, output int lat, output bit addr_ok);
    @(negedge clk);
    blk = din; decrypt = dec; start = 1'b1;
    @(negedge clk);
    start = 1'b0; blk = ~din; decrypt = ~dec;
    lat = 1; addr_ok = 1'b1;
    while (!done && lat < 100) begin
      if (key_addr != (dec ? 6'(33 - lat) : 6'(lat - 1))) addr_ok = 1'b0;
      if (poke && lat == 10) begin
        start = 1'b1; blk = rnd128();
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    res = result;
    if (!done) check(1'b0, "R5 timeout", 128'(lat), 128'd34);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] pt, ct, res, exp;
    int lat;
    bit aok;
    void'($urandom(32'd20240611));
    fill_keys(0);
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 done", 128'(done), 128'd0);
    check(result == '0, "R9 result", result, '0);
    rst_n = 1'b1;

    // directed: zero keys, zero data
    run_op('0, 1'b0, 1'b0, res, lat, aok);
    exp = ref_enc('0);
    check(res == exp, "R1 zero", res, exp);
    check(lat == 34, "R5 latency", 128'(lat), 128'd34);
    check(aok, "R4 enc addr", 128'(aok), 128'd1);
    @(negedge clk);
    check(done == 1'b0, "R6 pulse", 128'(done), 128'd0);

    // directed: all-ones keys and data, both directions
    fill_keys(1);
    run_op('1, 1'b0, 1'b0, res, lat, aok);
    exp = ref_enc('1);
    check(res == exp, "R1 ones", res, exp);
    run_op('1, 1'b1, 1'b0, res, lat, aok);
    exp = ref_dec('1);
    check(res == exp, "R2 ones", res, exp);
    check(aok, "R4 dec addr", 128'(aok), 128'd1);

    // random keys and blocks
    for (int it = 0; it < 12; it++) begin
      fill_keys(2);
      pt = rnd128();
      run_op(pt, 1'b0, 1'b0, ct, lat, aok);
      exp = ref_enc(pt);
      check(ct == exp, "R1 random enc", ct, exp);
      check(lat == 34 && aok, "R4/R5 enc timing", 128'(lat), 128'd34);
      run_op(ct, 1'b1, 1'b0, res, lat, aok);
      check(res == pt, "R3 round trip", res, pt);
      check(lat == 34 && aok, "R4/R5 dec timing", 128'(lat), 128'd34);
      pt = rnd128();
      run_op(pt, 1'b1, 1'b0, res, lat, aok);
      exp = ref_dec(pt);
      check(res == exp, "R2 random dec", res, exp);
      @(negedge clk);
      check(done == 1'b0, "R6 pulse", 128'(done), 128'd0);
    end

    // hold after done
    repeat (5) @(negedge clk);
    check(result == exp, "R8 hold", result, exp);

    // start while busy is ignored
    for (int it = 0; it < 2; it++) begin
      pt = rnd128();
      run_op(pt, it[0], 1'b1, res, lat, aok);
      exp = it[0] ? ref_dec(pt) : ref_enc(pt);
      check(res == exp, "R7 busy start result", res, exp);
      check(lat == 34 && aok, "R7 busy start timing", 128'(lat), 128'd34);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule